// File: doc/BRIEF.md
# Staggered RAS Refresh Sequencer

This block runs one refresh pass over a bank of DRAM rows, each selected by its own active-low row strobe. It does not pull every strobe low together. It lowers them one after another, a fixed number of clocks apart, so that the supply sees a series of small current steps rather than one large surge. The first strobe to fall is the one after the row that was open most recently, and the sequence wraps around from there. The row that was open therefore precharges while the other rows refresh, and it is refreshed last.

A plain `start` pulse begins the pass. With it come a mode bit and the index of the row that was open before the refresh. The mode selects between a row-address-only refresh and a column-strobe-first refresh. In row-address-only mode the block puts an internal refresh row address on the multiplexed address bus. In column-strobe-first mode it holds the column strobe low around the whole staggered window. When the pass ends, every strobe is high again, so the next memory access begins as a row miss. The block then signals `done` and `rows_closed`. It does not decide when to refresh and does not run normal reads or writes. There is no streaming data path, so every pin is a plain control or status line.

Top module: `ras_refresh_seq`

## Requirements
- R1: After reset, all `ras_n` bits are 1, `cas_n` is 1, `ma` is 0, `busy` and `done` are 0, and the refresh row counter is 0.
- R2: Tick 0 is the first cycle after the edge that accepts `start`. With previous row p, the strobe line (p+1+k) mod 6 falls at tick 1+k, for k = 0..5.
- R3: Each strobe line stays low for exactly 6 consecutive cycles during a pass. It is low at no other time.
- R4: The line of the previous row is the last to fall and stays high from tick 0 until its own slot. A `last_row` value of 6 or 7 is treated as 5, which gives the order 0,1,2,3,4,5.
- R5: `done` and `rows_closed` are 1 for exactly one cycle, at tick 12, when all strobes are high again. `busy` is 1 from tick 0 to tick 12 and is 0 in the cycle after tick 12.
- R6: In row-address-only mode (`cbr_mode`=0), `ma` carries the refresh row counter for the whole pass and `cas_n` stays 1.
- R7: In column-strobe-first mode (`cbr_mode`=1), `cas_n` is 0 from tick 0 through tick 11, so it leads the first strobe fall and covers the last strobe rise. It is 1 at tick 12, and `ma` is 0 for the whole pass.
- R8: The 11-bit refresh row counter advances by one after each completed pass and wraps from 2047 to 0.
- R9: A `start` pulse while `busy` is 1 is ignored. The running pass keeps its timing and the counter advances only once.
- R10: `cbr_mode` and `last_row` are sampled only when `start` is accepted. Changing them during a pass has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a refresh pass when idle |
| cbr_mode | input | 1 | 0 = row-address-only, 1 = column-strobe-first |
| last_row | input | 3 | Index of the most recently active row strobe |
| ras_n | output | 6 | Active-low row strobes |
| cas_n | output | 1 | Active-low column strobe (column-strobe-first mode) |
| ma | output | 11 | Multiplexed address bus carrying the refresh row |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| rows_closed | output | 1 | All rows closed, for the page-hit logic |

## Verification
The bench builds the block with its defaults: six strobe lines, six-clock hold, one-clock stagger and an 11-bit row counter. With these values the sweep can cover all eight `last_row` codes in both modes, including the two out-of-range codes. The 11-bit counter is also small enough that enough back-to-back passes run to carry it through 2047 and back to 0. Some passes receive a stray `start` and altered mode and row inputs in the middle. These passes show that a pass runs to completion on the values it latched at `start`.

// File: rtl/ras_rfsh_pkg.sv
package ras_rfsh_pkg;
  typedef enum logic {
    MODE_RAS_ONLY = 1'b0,
    MODE_CBR      = 1'b1
  } rfsh_mode_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int END_TICK = 12,
  parameter int TW       = $clog2(END_TICK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          accept,
  output logic          finish,
  output logic [TW-1:0] tick
);
  localparam logic [TW-1:0] LAST = TW'(END_TICK);

  assign accept = start && !busy;
  assign finish = busy && (tick == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      tick <= '0;
    end else if (busy) begin
      if (tick == LAST) begin
        busy <= 1'b0;
        tick <= '0;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish && !busy);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy && (tick == $past(tick) + 1'b1));
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (step)  count <= count + 1'b1;
  end

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == $past(count) + 1'b1);

  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));
endmodule

// File: rtl/rfsh_stagger.sv
module rfsh_stagger #(
  parameter int N    = 6,
  parameter int HOLD = 6,
  parameter int LEAD = 1,
  parameter int TW   = 4,
  parameter int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [TW-1:0] tick,
  input  logic [IW-1:0] prev_idx,
  output logic [N-1:0]  ras_n
);
  localparam int CW = $clog2(HOLD + 2);

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam logic [IW-1:0] IDX = IW'(i);
    logic [TW-1:0] pos;
    logic [TW-1:0] t_on;
    logic [TW-1:0] t_off;
    logic [CW-1:0] low_cnt;

    // slot of this line, counted from the line after prev_idx
    always_comb begin
      if (IDX > prev_idx) pos = TW'(IDX) - TW'(prev_idx) - 1'b1;
      else                pos = TW'(IDX) + TW'(N - 1) - TW'(prev_idx);
      t_on  = pos + TW'(LEAD);
      t_off = t_on + TW'(HOLD);
    end

    assign ras_n[i] = !(busy && (tick >= t_on) && (tick < t_off));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        low_cnt <= '0;
      end else if (!ras_n[i]) begin
        low_cnt <= low_cnt + 1'b1;
      end else begin
        // r3: a line returning high must have been low for HOLD clocks
        if (low_cnt != '0)
          a_r3_hold_len: assert (low_cnt == CW'(HOLD));
        low_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ras_refresh_seq.sv
module ras_refresh_seq
  import ras_rfsh_pkg::*;
#(
  parameter int N    = 6,
  parameter int HOLD = 6,
  parameter int LEAD = 1,
  parameter int AW   = 11,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cbr_mode,
  input  logic [SELW-1:0] last_row,
  output logic [N-1:0]    ras_n,
  output logic            cas_n,
  output logic [AW-1:0]   ma,
  output logic            busy,
  output logic            done,
  output logic            rows_closed
);
  localparam int END_TICK = LEAD + (N - 1) + HOLD;
  localparam int TW       = $clog2(END_TICK + 1);
  localparam int IW       = $clog2(N);

  logic          accept;
  logic          finish;
  logic [TW-1:0] tick;
  logic [AW-1:0] row_cnt;
  logic [IW-1:0] prev_q;
  rfsh_mode_e    mode_q;
  logic [N-1:0]  ras_q;

  rfsh_timer #(.END_TICK(END_TICK), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .accept(accept), .finish(finish), .tick(tick)
  );

  rfsh_row_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(finish), .count(row_cnt)
  );

  rfsh_stagger #(.N(N), .HOLD(HOLD), .LEAD(LEAD), .TW(TW), .IW(IW)) u_stag (
    .clk(clk), .rst_n(rst_n), .busy(busy), .tick(tick),
    .prev_idx(prev_q), .ras_n(ras_n)
  );

  // latch mode and previous row at accept; out-of-range rows map to N-1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RAS_ONLY;
      prev_q <= IW'(N - 1);
    end else if (accept) begin
      mode_q <= rfsh_mode_e'(cbr_mode);
      prev_q <= (int'(last_row) >= N) ? IW'(N - 1) : IW'(last_row);
    end
  end

  assign cas_n       = !(busy && (mode_q == MODE_CBR) && !finish);
  assign ma          = (busy && (mode_q == MODE_RAS_ONLY)) ? row_cnt : '0;
  assign done        = finish;
  assign rows_closed = finish && (&ras_n);

  always_ff @(posedge clk) begin
    if (!rst_n) ras_q <= '1;
    else        ras_q <= ras_n;
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      // r2: strobes fall strictly one per clock
      a_r2_one_fall: assert ($countones(ras_q & ~ras_n) <= 1);
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&ras_n) && cas_n);

  a_r7_cas_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CBR && !(&ras_n)) |-> !cas_n);

  a_r6_ronly_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == MODE_RAS_ONLY) |-> cas_n);

  a_r5_closed_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rows_closed);
endmodule

// File: tb/sim_ras_refresh_seq.sv
module sim_ras_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 6;
  localparam int HOLD = 6;
  localparam int LEAD = 1;
  localparam int AW   = 11;
  localparam int ENDT = LEAD + NL - 1 + HOLD;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            cbr_mode = 1'b0;
  logic [2:0]      last_row = 3'd0;
  logic [NL-1:0]   ras_n;
  logic            cas_n;
  logic [AW-1:0]   ma;
  logic            busy;
  logic            done;
  logic            rows_closed;

  int checks = 0;
  int fails  = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_refresh_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cbr_mode(cbr_mode),
    .last_row(last_row), .ras_n(ras_n), .cas_n(cas_n), .ma(ma),
    .busy(busy), .done(done), .rows_closed(rows_closed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NL-1:0] exp_ras(input int prev, input int t);
    logic [NL-1:0] r;
    int p = (prev >= NL) ? NL - 1 : prev;
    for (int i = 0; i < NL; i++) begin
      int pos = (i - p - 1 + NL) % NL;
      r[i] = !((t >= LEAD + pos) && (t < LEAD + pos + HOLD));
    end
    return r;
  endfunction

  // one pass; disturb drives a stray start and changed inputs mid-pass (R9, R10)
  task automatic run_pass(input bit mode, input int prev, input bit disturb);
    cbr_mode = mode;
    last_row = 3'(prev);
    start    = 1'b1;
    @(negedge clk);             // tick 0
    start = 1'b0;
    for (int t = 0; t <= ENDT; t++) begin
      if (disturb && t == 4) begin
        start    = 1'b1;
        cbr_mode = !mode;
        last_row = 3'(prev + 2);
      end
      if (disturb && t == 5) start = 1'b0;
      check(disturb ? "R2/R3/R4/R10 ras_n" : "R2/R3/R4 ras_n", 32'(ras_n), 32'(exp_ras(prev, t)));
      check(mode ? "R7 cas_n" : "R6 cas_n", 32'(cas_n),
            32'(mode ? (t < ENDT ? 0 : 1) : 1));
      check(mode ? "R7 ma" : "R6/R8 ma", 32'(ma), mode ? 32'd0 : 32'(exp_cnt));
      check("R5 done", {30'd0, done, rows_closed}, (t == ENDT) ? 32'd3 : 32'd0);
      check(disturb ? "R9 busy" : "R5 busy", 32'(busy), 32'd1);
      @(negedge clk);
    end
    cbr_mode = 1'b0;
    check("R5 idle after done", {29'd0, busy, done, &ras_n}, 32'd1);
    exp_cnt = (exp_cnt + 1) % (1 << AW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ras_n", 32'(ras_n), 32'h3F);
    check("R1 cas_n", 32'(cas_n), 32'd1);
    check("R1 ma", 32'(ma), 32'd0);
    check("R1 busy/done", {30'd0, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {29'd0, busy, done, &ras_n}, 32'd1);

    // sweep all last_row codes in both modes (R2, R4, R6, R7)
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 8; p++)
        run_pass(m[0], p, 1'b0);

    // disturbed passes (R9, R10)
    for (int p = 0; p < 6; p++)
      run_pass(p[0], p, 1'b1);

    // run the counter through its wrap (R8)
    while (exp_cnt != 3) run_pass(1'b0, exp_cnt % 8, 1'b0);

    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule